// File: doc/BRIEF.md
# Register file with pointer-pair ports

This block is the general-purpose register store of a small pipelined microcontroller core. It holds 32 byte-wide registers behind two independent registered read ports and one byte-wide write port. The six highest registers also act as three 16-bit address pointers, named X, Y and Z. Each pointer has a combinational value output and a 16-bit write port of its own.

The pipeline can use all six ports in the same clock cycle. A pointer update, such as an auto-increment after a memory access, can land in the same cycle as an ordinary result written back to a byte of that same pointer. In that case the pointer port wins. Both reads in that cycle still return the contents as they stood before the edge.

The store is cleared by an active-low asynchronous reset and by an active-high synchronous reset. A synchronous reset overrides every write and read in its cycle.

Top module: `regfile_ptr`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, register `wr_addr` (0 to 31) takes `wr_data`.
- R2: When `rda_en` is high at a rising edge, `rda_data` takes the value that register `rda_addr` held before that edge. A write to the same address in that cycle is not visible until a later read. When `rda_en` is low, `rda_data` holds its value.
- R3: Read port B (`rdb_addr`, `rdb_en`, `rdb_data`) behaves as in R2, independently of port A.
- R4: `ptr_x_val` is {reg27, reg26}, `ptr_y_val` is {reg29, reg28` and `ptr_z_val` is {reg31, reg30}, with the high byte in bits 15:8. These outputs are combinational and reflect a write from the cycle after its edge. These registers can be read and written through the 8-bit ports like any other register.
- R5: When a pointer write strobe (`ptr_x_we`, `ptr_y_we` or `ptr_z_we`) is high at a rising edge, both bytes of that pair take the matching 16-bit input: low byte from bits 7:0, high byte from bits 15:8.
- R6: If a pointer write and the general write target the same byte in one cycle, the byte stores the pointer write's data.
- R7: Pointer write ports never change registers 0 to 25. A general write to registers 0 to 25 never changes any pointer output.
- R8: Both reads, the general write and all three pointer writes take effect correctly when all are used in one cycle.
- R9: While `arst_n` is low, all 32 registers and both read outputs are zero, without waiting for a clock edge.
- R10: When `srst` is high at a rising edge, all registers and both read outputs become zero. Any write or read in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| arst_n | input | 1 | Asynchronous clear, active low |
| srst | input | 1 | Synchronous clear, active high |
| rda_addr | input | 5 | Read port A register address |
| rda_en | input | 1 | Read port A strobe |
| rda_data | output | 8 | Read port A registered data |
| rdb_addr | input | 5 | Read port B register address |
| rdb_en | input | 1 | Read port B strobe |
| rdb_data | output | 8 | Read port B registered data |
| wr_addr | input | 5 | General write address |
| wr_en | input | 1 | General write strobe |
| wr_data | input | 8 | General write data |
| ptr_x_val | output | 16 | X pointer value {reg27, reg26} |
| ptr_x_we | input | 1 | X pointer write strobe |
| ptr_x_din | input | 16 | X pointer write data |
| ptr_y_val | output | 16 | Y pointer value {reg29, reg28} |
| ptr_y_we | input | 1 | Y pointer write strobe |
| ptr_y_din | input | 16 | Y pointer write data |
| ptr_z_val | output | 16 | Z pointer value {reg31, reg30} |
| ptr_z_we | input | 1 | Z pointer write strobe |
| ptr_z_din | input | 16 | Z pointer write data |

## Verification
The hardest situation to reach is a single cycle with three kinds of traffic at once:
- the general write and a pointer write both land on the same pointer byte;
- both read ports sample bytes of a pointer that is being rewritten;
- the other two pointers are also written.

One vector row drives all six ports at once, and the expected read data is the pre-edge pointer contents. The next row reads the contested byte back through an 8-bit port, so the winner is seen at the ports. Another row pairs a general write to a low register with writes to all three pointers, and the next row reads that register back.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int RF_DEPTH    = 32;
    localparam int RF_DW       = 8;
    localparam int RF_AW       = $clog2(RF_DEPTH);
    localparam int RF_NPTR     = 3;
    localparam int RF_PTR_BASE = RF_DEPTH - 2 * RF_NPTR;
    localparam int RF_NRD      = 2;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int AW    = 5,
    parameter int NPTR  = 3,
    parameter int PBASE = 26
) (
    input  logic                           clk,
    input  logic                           arst_n,
    input  logic                           srst,
    input  logic                           wr_en,
    input  logic [AW-1:0]                  wr_addr,
    input  logic [DW-1:0]                  wr_data,
    input  logic [NPTR-1:0]                ptr_we,
    input  logic [NPTR-1:0][2*DW-1:0]      ptr_din,
    output logic [DEPTH-1:0][DW-1:0]       regs_q
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        logic          load;
        logic [DW-1:0] nxt;
        logic          gen_hit;

        assign gen_hit = wr_en && (wr_addr == AW'(i));

        if (i >= PBASE && i < PBASE + 2 * NPTR) begin : g_ptr
            localparam int K = (i - PBASE) / 2;
            localparam int B = (i - PBASE) % 2;
            // pointer port outranks the general port on a shared byte
            always_comb begin
                if (ptr_we[K]) begin
                    load = 1'b1;
                    nxt  = ptr_din[K][B*DW +: DW];
                end else begin
                    load = gen_hit;
                    nxt  = wr_data;
                end
            end
        end else begin : g_plain
            always_comb begin
                load = gen_hit;
                nxt  = wr_data;
            end
        end

        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)
                regs_q[i] <= '0;
            else if (srst)
                regs_q[i] <= '0;
            else if (load)
                regs_q[i] <= nxt;
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int AW    = 5
) (
    input  logic                     clk,
    input  logic                     arst_n,
    input  logic                     srst,
    input  logic                     en,
    input  logic [AW-1:0]            addr,
    input  logic [DEPTH-1:0][DW-1:0] regs,
    output logic [DW-1:0]            data
);
    logic [DW-1:0] sel;

    assign sel = regs[addr];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            data <= '0;
        else if (srst)
            data <= '0;
        else if (en)
            data <= sel;
    end
endmodule

// File: rtl/rf_ptr_view.sv
module rf_ptr_view #(
    parameter int DW   = 8,
    parameter int NPTR = 3
) (
    input  logic [2*NPTR-1:0][DW-1:0] pair_regs,
    output logic [NPTR-1:0][2*DW-1:0] ptr_val
);
    for (genvar k = 0; k < NPTR; k++) begin : g_view
        assign ptr_val[k] = {pair_regs[2*k+1], pair_regs[2*k]};
    end
endmodule

// File: rtl/regfile_ptr.sv
module regfile_ptr
    import rf_pkg::*;
#(
    parameter  int DEPTH = RF_DEPTH,
    parameter  int DW    = RF_DW,
    localparam int AW    = $clog2(DEPTH),
    localparam int NPTR  = RF_NPTR,
    localparam int PBASE = DEPTH - 2 * NPTR,
    localparam int NRD   = RF_NRD
) (
    input  logic            clk,
    input  logic            arst_n,
    input  logic            srst,
    input  logic [AW-1:0]   rda_addr,
    input  logic            rda_en,
    output logic [DW-1:0]   rda_data,
    input  logic [AW-1:0]   rdb_addr,
    input  logic            rdb_en,
    output logic [DW-1:0]   rdb_data,
    input  logic [AW-1:0]   wr_addr,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    output logic [2*DW-1:0] ptr_x_val,
    input  logic            ptr_x_we,
    input  logic [2*DW-1:0] ptr_x_din,
    output logic [2*DW-1:0] ptr_y_val,
    input  logic            ptr_y_we,
    input  logic [2*DW-1:0] ptr_y_din,
    output logic [2*DW-1:0] ptr_z_val,
    input  logic            ptr_z_we,
    input  logic [2*DW-1:0] ptr_z_din
);
    logic [DEPTH-1:0][DW-1:0]   regs_q;
    logic [NPTR-1:0]            ptr_we;
    logic [NPTR-1:0][2*DW-1:0]  ptr_din;
    logic [NPTR-1:0][2*DW-1:0]  ptr_val;
    logic [NRD-1:0][AW-1:0]     rd_addr;
    logic [NRD-1:0]             rd_en;
    logic [NRD-1:0][DW-1:0]     rd_data;

    // index 0 = X, 1 = Y, 2 = Z
    assign ptr_we  = {ptr_z_we, ptr_y_we, ptr_x_we};
    assign ptr_din = {ptr_z_din, ptr_y_din, ptr_x_din};
    assign ptr_x_val = ptr_val[0];
    assign ptr_y_val = ptr_val[1];
    assign ptr_z_val = ptr_val[2];

    assign rd_addr = {rdb_addr, rda_addr};
    assign rd_en   = {rdb_en, rda_en};
    assign rda_data = rd_data[0];
    assign rdb_data = rd_data[1];

    rf_storage #(
        .DEPTH(DEPTH), .DW(DW), .AW(AW), .NPTR(NPTR), .PBASE(PBASE)
    ) u_store (
        .clk     (clk),
        .arst_n  (arst_n),
        .srst    (srst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ptr_we  (ptr_we),
        .ptr_din (ptr_din),
        .regs_q  (regs_q)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rf_read_port #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_rd (
            .clk    (clk),
            .arst_n (arst_n),
            .srst   (srst),
            .en     (rd_en[p]),
            .addr   (rd_addr[p]),
            .regs   (regs_q),
            .data   (rd_data[p])
        );
    end

    rf_ptr_view #(.DW(DW), .NPTR(NPTR)) u_view (
        .pair_regs (regs_q[DEPTH-1:PBASE]),
        .ptr_val   (ptr_val)
    );
endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import rf_pkg::*;
(
    input logic                clk,
    input logic                arst_n,
    input logic                srst,
    input logic [RF_AW-1:0]    rda_addr,
    input logic                rda_en,
    input logic [RF_DW-1:0]    rda_data,
    input logic                rdb_en,
    input logic [RF_DW-1:0]    rdb_data,
    input logic [RF_AW-1:0]    wr_addr,
    input logic                wr_en,
    input logic [2*RF_DW-1:0]  ptr_x_val,
    input logic                ptr_x_we,
    input logic [2*RF_DW-1:0]  ptr_x_din,
    input logic [2*RF_DW-1:0]  ptr_y_val,
    input logic                ptr_y_we,
    input logic [2*RF_DW-1:0]  ptr_z_val,
    input logic                ptr_z_we,
    input logic [2*RF_DW-1:0]  ptr_z_din
);
    p_read_hold_r2: assert property (@(posedge clk) disable iff (!arst_n)
        (!srst && !rda_en) |=> $stable(rda_data));

    p_read_hold_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (!srst && !rdb_en) |=> $stable(rdb_data));

    p_read_old_byte_r2: assert property (@(posedge clk) disable iff (!arst_n)
        (!srst && rda_en && rda_addr == RF_AW'(RF_PTR_BASE))
        |=> rda_data == $past(ptr_x_val[RF_DW-1:0]));

    p_ptr_write_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (!srst && ptr_x_we) |=> ptr_x_val == $past(ptr_x_din));

    p_ptr_wins_r6: assert property (@(posedge clk) disable iff (!arst_n)
        (!srst && ptr_z_we && wr_en && wr_addr == RF_AW'(RF_DEPTH - 1))
        |=> ptr_z_val == $past(ptr_z_din));

    p_low_write_isolated_r7: assert property (@(posedge clk) disable iff (!arst_n)
        (!srst && wr_en && wr_addr < RF_AW'(RF_PTR_BASE)
         && !ptr_x_we && !ptr_y_we && !ptr_z_we)
        |=> ($stable(ptr_x_val) && $stable(ptr_y_val) && $stable(ptr_z_val)));

    p_sync_clear_r10: assert property (@(posedge clk) disable iff (!arst_n)
        srst |=> (rda_data == '0 && rdb_data == '0 && ptr_x_val == '0
                  && ptr_y_val == '0 && ptr_z_val == '0));
endmodule

bind regfile_ptr rf_checker u_chk (.*);

// File: tb/tb_regfile_ptr.sv
module tb_regfile_ptr;
    logic        clk = 1'b0;
    logic        arst_n, srst;
    logic [4:0]  rda_addr, rdb_addr, wr_addr;
    logic        rda_en, rdb_en, wr_en;
    logic [7:0]  wr_data, rda_data, rdb_data;
    logic [15:0] ptr_x_val, ptr_y_val, ptr_z_val;
    logic [15:0] ptr_x_din, ptr_y_din, ptr_z_din;
    logic        ptr_x_we, ptr_y_we, ptr_z_we;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    regfile_ptr dut (.*);

    typedef struct packed {
        logic [4:0]  ra;  logic rae;
        logic [4:0]  rb;  logic rbe;
        logic [4:0]  wa;  logic we;  logic [7:0] wd;
        logic        xwe; logic [15:0] xd;
        logic        ywe; logic [15:0] yd;
        logic        zwe; logic [15:0] zd;
        logic [7:0]  ea;  logic [7:0]  eb;
        logic [15:0] ex;  logic [15:0] ey; logic [15:0] ez;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [0:NV-1] = '{
        // R1 write r10
        '{5'd0, 1'b0, 5'd0, 1'b0, 5'd10, 1'b1, 8'h32, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0,
          8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 4'd1},
        // R2 read A r10, write r11
        '{5'd10, 1'b1, 5'd0, 1'b0, 5'd11, 1'b1, 8'h33, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0,
          8'h32, 8'h00, 16'h0000, 16'h0000, 16'h0000, 4'd2},
        // R3 read B r11, A idle holds
        '{5'd11, 1'b0, 5'd11, 1'b1, 5'd0, 1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0,
          8'h32, 8'h33, 16'h0000, 16'h0000, 16'h0000, 4'd3},
        // R4 general write r26 shows in X low byte
        '{5'd0, 1'b0, 5'd0, 1'b0, 5'd26, 1'b1, 8'h3C, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0,
          8'h32, 8'h33, 16'h003C, 16'h0000, 16'h0000, 4'd4},
        // R4 r27 is X high byte
        '{5'd0, 1'b0, 5'd0, 1'b0, 5'd27, 1'b1, 8'h3D, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0,
          8'h32, 8'h33, 16'h3D3C, 16'h0000, 16'h0000, 4'd4},
        // R4 read r26, write r31 (Z high)
        '{5'd26, 1'b1, 5'd0, 1'b0, 5'd31, 1'b1, 8'h41, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0,
          8'h3C, 8'h33, 16'h3D3C, 16'h0000, 16'h4100, 4'd4},
        // R2 read and write r27 in one cycle: old value returned
        '{5'd27, 1'b1, 5'd0, 1'b0, 5'd27, 1'b1, 8'h99, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0,
          8'h3D, 8'h33, 16'h993C, 16'h0000, 16'h4100, 4'd2},
        // R5 all pointer writes, B reads old r30
        '{5'd0, 1'b0, 5'd30, 1'b1, 5'd0, 1'b0, 8'h00, 1'b1, 16'h1111, 1'b1, 16'h2222, 1'b1, 16'h3333,
          8'h3D, 8'h00, 16'h1111, 16'h2222, 16'h3333, 4'd5},
        // R4 pointer bytes readable via 8-bit ports
        '{5'd31, 1'b1, 5'd28, 1'b1, 5'd0, 1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0,
          8'h33, 8'h22, 16'h1111, 16'h2222, 16'h3333, 4'd4},
        // R8 all six ports; R6 general and Z both hit r31
        '{5'd30, 1'b1, 5'd31, 1'b1, 5'd31, 1'b1, 8'h78, 1'b1, 16'h0079, 1'b1, 16'h007A, 1'b1, 16'h007B,
          8'h33, 8'h33, 16'h0079, 16'h007A, 16'h007B, 4'd8},
        // R6 contested byte holds pointer data
        '{5'd0, 1'b0, 5'd31, 1'b1, 5'd0, 1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0,
          8'h33, 8'h00, 16'h0079, 16'h007A, 16'h007B, 4'd6},
        // R7 write r10 alongside all pointer writes
        '{5'd10, 1'b1, 5'd0, 1'b0, 5'd10, 1'b1, 8'h6E, 1'b1, 16'hABCD, 1'b1, 16'h1234, 1'b1, 16'h5678,
          8'h32, 8'h00, 16'hABCD, 16'h1234, 16'h5678, 4'd7},
        // R7 r10 kept general data; low write leaves pointers
        '{5'd10, 1'b1, 5'd0, 1'b0, 5'd5, 1'b1, 8'h55, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0,
          8'h6E, 8'h00, 16'hABCD, 16'h1234, 16'h5678, 4'd7},
        // R1 read back r5
        '{5'd0, 1'b0, 5'd5, 1'b1, 5'd0, 1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0,
          8'h6E, 8'h55, 16'hABCD, 16'h1234, 16'h5678, 4'd1}
    };

    task automatic idle();
        rda_addr = '0; rda_en = 1'b0; rdb_addr = '0; rdb_en = 1'b0;
        wr_addr = '0; wr_en = 1'b0; wr_data = '0;
        ptr_x_we = 1'b0; ptr_x_din = '0; ptr_y_we = 1'b0; ptr_y_din = '0;
        ptr_z_we = 1'b0; ptr_z_din = '0;
    endtask

    task automatic check_all(string tag, logic [7:0] ea, logic [7:0] eb,
                             logic [15:0] ex, logic [15:0] ey, logic [15:0] ez);
        n_vec++;
        if (rda_data !== ea || rdb_data !== eb || ptr_x_val !== ex
            || ptr_y_val !== ey || ptr_z_val !== ez) begin
            n_bad++;
            $display("FAIL %s: got a=%h b=%h x=%h y=%h z=%h expected a=%h b=%h x=%h y=%h z=%h",
                     tag, rda_data, rdb_data, ptr_x_val, ptr_y_val, ptr_z_val,
                     ea, eb, ex, ey, ez);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle();
        srst = 1'b0;
        arst_n = 1'b1;
        #1 arst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_all("R9 reset state", 8'h00, 8'h00, 16'h0, 16'h0, 16'h0);
        arst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            rda_addr = VECS[i].ra;  rda_en = VECS[i].rae;
            rdb_addr = VECS[i].rb;  rdb_en = VECS[i].rbe;
            wr_addr  = VECS[i].wa;  wr_en  = VECS[i].we;  wr_data = VECS[i].wd;
            ptr_x_we = VECS[i].xwe; ptr_x_din = VECS[i].xd;
            ptr_y_we = VECS[i].ywe; ptr_y_din = VECS[i].yd;
            ptr_z_we = VECS[i].zwe; ptr_z_din = VECS[i].zd;
            @(negedge clk);
            check_all($sformatf("vector %0d R%0d", i, VECS[i].req),
                      VECS[i].ea, VECS[i].eb, VECS[i].ex, VECS[i].ey, VECS[i].ez);
        end

        // R10: sync clear beats a write and a read in the same cycle
        idle();
        srst = 1'b1;
        wr_addr = 5'd10; wr_en = 1'b1; wr_data = 8'hEE;
        rda_addr = 5'd10; rda_en = 1'b1; rdb_addr = 5'd5; rdb_en = 1'b1;
        ptr_y_we = 1'b1; ptr_y_din = 16'hFFFF;
        @(negedge clk);
        check_all("R10 sync clear", 8'h00, 8'h00, 16'h0, 16'h0, 16'h0);
        idle();
        srst = 1'b0;
        rda_addr = 5'd10; rda_en = 1'b1; rdb_addr = 5'd5; rdb_en = 1'b1;
        @(negedge clk);
        check_all("R10 write dropped", 8'h00, 8'h00, 16'h0, 16'h0, 16'h0);

        // R9: async clear with no clock edge
        idle();
        wr_addr = 5'd12; wr_en = 1'b1; wr_data = 8'h5A;
        ptr_x_we = 1'b1; ptr_x_din = 16'hBEEF;
        @(negedge clk);
        idle();
        rda_addr = 5'd12; rda_en = 1'b1;
        @(negedge clk);
        check_all("R9 preload", 8'h5A, 8'h00, 16'hBEEF, 16'h0, 16'h0);
        idle();
        #1 arst_n = 1'b0;
        #0.5;
        check_all("R9 async clear before edge", 8'h00, 8'h00, 16'h0, 16'h0, 16'h0);
        @(negedge clk);
        arst_n = 1'b1;
        rda_addr = 5'd12; rda_en = 1'b1;
        @(negedge clk);
        check_all("R9 register cleared", 8'h00, 8'h00, 16'h0, 16'h0, 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule